// File: doc/BRIEF.md
# DDR2 Off-Chip Driver Calibration Responder

This block sits on the memory-device side of DDR2 off-chip driver calibration. It decodes a three-bit calibration mode code carried with a mode command. Two of the modes put the data and strobe outputs at fixed levels, so that a controller can measure driver impedance on them. An adjust mode accepts a short write burst carrying an impedance step code. An exit code releases the drivers.

A mode command reaches the outputs a fixed number of clocks later, set by the parameter `TOIT`. A newer command issued inside that window replaces the pending one and starts the wait again. In adjust mode, a write strobe opens a capture window. One calibration bit is sampled per clock from data line 0, starting at write latency `AL + CL - 1` and lasting four beats. The four bits form a code that steps a pull-up strength register and a pull-down strength register by one step each, or leaves them unchanged.

Top module: `ocd_cal_responder`

## Requirements
- R1: After reset the drivers are off (`dq_oe` = 0), every value output is 0, both strength registers hold 8 and the block is in exit mode.
- R2: Mode codes are 3'b001 drive-high, 3'b010 drive-low, 3'b100 adjust and 3'b000 exit. Any other code on `cmd_valid` is ignored: the outputs, the pending countdown and the current mode stay as they were.
- R3: For a drive-high command sampled at clock edge t, the outputs keep their previous values through edge t+TOIT-1. After edge t+TOIT, `dq_oe` = 1, every `dq_out` bit = 1, `dqs_out` = 1 and `dqs_n_out` = 0.
- R4: For a drive-low command sampled at edge t, after edge t+TOIT `dq_oe` = 1, every `dq_out` bit = 0, `dqs_out` = 0 and `dqs_n_out` = 1. Before that edge the previous values remain.
- R5: For an exit or adjust command sampled at edge t, the drivers turn off after edge t+TOIT. While `dq_oe` = 0, every value output reads 0.
- R6: A valid mode command that arrives while a countdown is running drops the earlier target. The outputs then change TOIT clocks after the newer command, to the newer target.
- R7: In adjust mode, a write strobe sampled at edge t takes beat DT0 from `dq0_in` at edge t+WL, where WL = AL+CL-1. DT1, DT2 and DT3 are taken at the next three edges. The order is always DT0 to DT3.
- R8: The code is {DT0,DT1,DT2,DT3}. {DT0,DT1} steps the pull-up register and {DT2,DT3} steps the pull-down register. In each field, 01 means increase by one, 10 means decrease by one, and 00 or the reserved 11 means no change. The update is visible after the DT3 edge.
- R9: Each strength register stays at 15 on an increase and stays at 0 on a decrease.
- R10: A write strobe is ignored when the block is not in adjust mode, and also when a capture window is already open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Mode command strobe |
| cmd_code | input | 3 | Calibration mode code |
| wr_cmd | input | 1 | Write command strobe |
| dq0_in | input | 1 | Calibration data bit from data line 0 |
| dq_oe | output | 1 | Output enable for DQ and DQS drivers |
| dq_out | output | DQ_W | Driven DQ levels |
| dqs_out | output | 1 | Driven true strobe level |
| dqs_n_out | output | 1 | Driven complement strobe level |
| pu_strength | output | STR_W | Pull-up strength code |
| pd_strength | output | STR_W | Pull-down strength code |

## Verification
The hardest case to reach from the ports is a second write strobe that arrives while a capture window is already open. A design that wrongly accepts it only shows the error several clocks later, when the stray capture changes a strength register. To expose it, the bench asserts the second strobe during beat DT1 of a no-change burst. It then drives an alternating bit pattern for several clocks, so that any four beats taken from that stretch would step the pull-down register. The restart rule is reached in the same way: a second mode command is sent one clock after the first, and the outputs are checked in the cycle where the old target would have appeared.

// File: rtl/ocd_cal_pkg.sv
package ocd_cal_pkg;

    typedef enum logic [2:0] {
        OCD_EXIT   = 3'b000,
        OCD_DRV_HI = 3'b001,
        OCD_DRV_LO = 3'b010,
        OCD_ADJUST = 3'b100
    } ocd_mode_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DOWN = 2'b10,
        STEP_RSVD = 2'b11
    } step_e;

    function automatic logic mode_code_known(input logic [2:0] code);
        return (code == OCD_EXIT) || (code == OCD_DRV_HI) ||
               (code == OCD_DRV_LO) || (code == OCD_ADJUST);
    endfunction

endpackage

// File: rtl/ocd_drive_ctrl.sv
module ocd_drive_ctrl
    import ocd_cal_pkg::*;
#(
    parameter int TOIT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    output logic       adjust_mode,
    output logic       drv_oe,
    output logic       drv_level
);
    localparam int TW = $clog2(TOIT + 1);

    typedef struct packed {
        ocd_mode_e     mode;
        logic [TW-1:0] tmr;
        logic          tgt_oe;
        logic          tgt_lvl;
        logic          oe;
        logic          lvl;
    } drv_state_t;

    drv_state_t st_d, st_q;
    logic       cmd_ok;

    always_comb begin
        st_d   = st_q;
        cmd_ok = cmd_valid && mode_code_known(cmd_code);
        if (cmd_ok) begin
            // a new command replaces any pending target and restarts the wait
            st_d.mode    = ocd_mode_e'(cmd_code);
            st_d.tmr     = TW'(TOIT);
            st_d.tgt_oe  = (cmd_code == OCD_DRV_HI) || (cmd_code == OCD_DRV_LO);
            st_d.tgt_lvl = (cmd_code == OCD_DRV_HI);
        end else if (st_q.tmr != '0) begin
            st_d.tmr = st_q.tmr - 1'b1;
            if (st_q.tmr == TW'(1)) begin
                st_d.oe  = st_q.tgt_oe;
                st_d.lvl = st_q.tgt_lvl;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: OCD_EXIT, tmr: '0, tgt_oe: 1'b0, tgt_lvl: 1'b0,
                      oe: 1'b0, lvl: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign adjust_mode = (st_q.mode == OCD_ADJUST);
    assign drv_oe      = st_q.oe;
    assign drv_level   = st_q.lvl;

    // outputs move only at the end of a countdown
    assert_no_early_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tmr == '0 && !cmd_ok) |=> ($stable(st_q.oe) && $stable(st_q.lvl)));

    // unknown codes leave mode and countdown alone
    assert_rsvd_code_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !mode_code_known(cmd_code) && st_q.tmr == '0)
            |=> ($stable(st_q.mode) && st_q.tmr == '0));

    // an accepted command always restarts the full wait
    assert_restart_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ok |=> (st_q.tmr == TW'(TOIT)));

endmodule

// File: rtl/ocd_adjust_capture.sv
module ocd_adjust_capture #(
    parameter int WL = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adjust_mode,
    input  logic       wr_cmd,
    input  logic       beat_bit,
    output logic       code_vld,
    output logic [3:0] code
);
    localparam int LW = $clog2(WL + 1);

    typedef struct packed {
        logic [LW-1:0] lat;
        logic          cap;
        logic [1:0]    beat;
        logic [2:0]    sh;
    } cap_state_t;

    cap_state_t cs_d, cs_q;

    always_comb begin
        cs_d     = cs_q;
        code_vld = 1'b0;
        code     = {cs_q.sh, beat_bit};
        if (cs_q.lat != '0) begin
            cs_d.lat = cs_q.lat - 1'b1;
            if (cs_q.lat == LW'(1)) begin
                cs_d.cap  = 1'b1;
                cs_d.beat = 2'd1;
                cs_d.sh   = {2'b00, beat_bit};
            end
        end else if (cs_q.cap) begin
            if (cs_q.beat == 2'd3) begin
                code_vld  = 1'b1;
                cs_d.cap  = 1'b0;
                cs_d.beat = 2'd0;
            end else begin
                cs_d.beat = cs_q.beat + 1'b1;
                cs_d.sh   = {cs_q.sh[1:0], beat_bit};
            end
        end else if (wr_cmd && adjust_mode) begin
            cs_d.lat = LW'(WL);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    // latency wait and beat collection never overlap
    assert_phase_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.lat != '0) |-> !cs_q.cap);

    // a strobe outside adjust mode opens nothing
    assert_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !adjust_mode && cs_q.lat == '0 && !cs_q.cap)
            |=> (cs_q.lat == '0 && !cs_q.cap));

endmodule

// File: rtl/ocd_strength_step.sv
module ocd_strength_step
    import ocd_cal_pkg::*;
#(
    parameter int STR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply,
    input  logic [1:0]       step,
    output logic [STR_W-1:0] strength
);
    localparam logic [STR_W-1:0] STR_MAX = '1;
    localparam logic [STR_W-1:0] STR_MID = STR_W'(1) << (STR_W - 1);

    logic [STR_W-1:0] str_d, str_q;

    always_comb begin
        str_d = str_q;
        if (apply) begin
            if (step == STEP_UP && str_q != STR_MAX) begin
                str_d = str_q + 1'b1;
            end else if (step == STEP_DOWN && str_q != '0) begin
                str_d = str_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            str_q <= STR_MID;
        end else begin
            str_q <= str_d;
        end
    end

    assign strength = str_q;

    assert_hold_without_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(str_q));

    assert_ceiling_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && step == STEP_UP && str_q == STR_MAX) |=> (str_q == STR_MAX));

    assert_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && step == STEP_DOWN && str_q == '0) |=> (str_q == '0));

endmodule

// File: rtl/ocd_cal_responder.sv
module ocd_cal_responder #(
    parameter int AL    = 0,
    parameter int CL    = 3,
    parameter int TOIT  = 2,
    parameter int DQ_W  = 8,
    parameter int STR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_code,
    input  logic             wr_cmd,
    input  logic             dq0_in,
    output logic             dq_oe,
    output logic [DQ_W-1:0]  dq_out,
    output logic             dqs_out,
    output logic             dqs_n_out,
    output logic [STR_W-1:0] pu_strength,
    output logic [STR_W-1:0] pd_strength
);
    localparam int WL = AL + CL - 1;

    logic                        adj_mode;
    logic                        oe_w;
    logic                        lvl_w;
    logic                        code_vld;
    logic [3:0]                  code;
    logic [1:0][STR_W-1:0]       str_w;

    ocd_drive_ctrl #(.TOIT(TOIT)) u_drive (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .adjust_mode (adj_mode),
        .drv_oe      (oe_w),
        .drv_level   (lvl_w)
    );

    ocd_adjust_capture #(.WL(WL)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .adjust_mode (adj_mode),
        .wr_cmd      (wr_cmd),
        .beat_bit    (dq0_in),
        .code_vld    (code_vld),
        .code        (code)
    );

    // index 0: pull-up from {DT0,DT1}; index 1: pull-down from {DT2,DT3}
    for (genvar g = 0; g < 2; g++) begin : g_str
        ocd_strength_step #(.STR_W(STR_W)) u_step (
            .clk      (clk),
            .rst_n    (rst_n),
            .apply    (code_vld),
            .step     (code[2*(1-g) +: 2]),
            .strength (str_w[g])
        );
    end

    assign dq_oe       = oe_w;
    assign dq_out      = {DQ_W{oe_w & lvl_w}};
    assign dqs_out     = oe_w & lvl_w;
    assign dqs_n_out   = oe_w & ~lvl_w;
    assign pu_strength = str_w[0];
    assign pd_strength = str_w[1];

    // strengths only move on a completed four-beat capture
    assert_strength_needs_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !code_vld |=> ($stable(pu_strength) && $stable(pd_strength)));

endmodule

// File: tb/ocd_cal_responder_bench.sv
`timescale 1ns/100ps
module ocd_cal_responder_bench;
    localparam int AL = 0, CL = 3, TOIT = 2, DQ_W = 8, STR_W = 4;
    localparam int WL = AL + CL - 1;
    localparam int SMAX = (1 << STR_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, wr_cmd = 1'b0, dq0_in = 1'b0;
    logic [2:0] cmd_code = 3'b000;
    logic dq_oe, dqs_out, dqs_n_out;
    logic [DQ_W-1:0] dq_out;
    logic [STR_W-1:0] pu_strength, pd_strength;

    int checks = 0, failures = 0, exp_pu = 8, exp_pd = 8;
    bit done = 0;

    always #2.5 clk = ~clk;

    ocd_cal_responder #(.AL(AL), .CL(CL), .TOIT(TOIT), .DQ_W(DQ_W), .STR_W(STR_W))
    u_ocd_cal_responder (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .wr_cmd(wr_cmd), .dq0_in(dq0_in), .dq_oe(dq_oe), .dq_out(dq_out),
        .dqs_out(dqs_out), .dqs_n_out(dqs_n_out),
        .pu_strength(pu_strength), .pd_strength(pd_strength)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // off: oe=0 all zero; level 1/0: driven
    task automatic chk_drv(input string req, input int st);
        if (st < 0) begin
            chk({req, " oe"}, dq_oe, 0);
            chk({req, " dq"}, dq_out, 0);
            chk({req, " dqs/dqs_n"}, {dqs_out, dqs_n_out}, 0);
        end else begin
            chk({req, " oe"}, dq_oe, 1);
            chk({req, " dq"}, dq_out, st ? (1 << DQ_W) - 1 : 0);
            chk({req, " dqs"}, dqs_out, st);
            chk({req, " dqs_n"}, dqs_n_out, 1 - st);
        end
    endtask

    task automatic send_cmd(input logic [2:0] c);
        cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 3'b000;
    endtask

    function automatic int step_val(input int v, input logic [1:0] f);
        if (f == 2'b01) return (v < SMAX) ? v + 1 : v;
        if (f == 2'b10) return (v > 0) ? v - 1 : v;
        return v;
    endfunction

    // write strobe, WL lead-in with decoy bits, then DT0..DT3 in fixed order
    task automatic burst(input logic [3:0] c, input bit second_wr);
        wr_cmd = 1'b1; dq0_in = ~c[3];
        @(negedge clk);
        wr_cmd = 1'b0;
        repeat (WL - 1) begin dq0_in = ~c[3]; @(negedge clk); end
        for (int b = 0; b < 4; b++) begin
            dq0_in = c[3-b];
            wr_cmd = second_wr && (b == 1);
            @(negedge clk);
        end
        wr_cmd = 1'b0; dq0_in = ~c[0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_drv("R1 reset", -1);
        chk("R1 reset pu", pu_strength, 8);
        chk("R1 reset pd", pd_strength, 8);

        // R10: write while in exit mode has no effect
        burst(4'b0101, 0);
        repeat (2) @(negedge clk);
        chk("R10 pu outside adjust", pu_strength, 8);
        chk("R10 pd outside adjust", pd_strength, 8);

        // R3 drive-high with tOIT delay
        send_cmd(3'b001);
        repeat (TOIT - 1) @(negedge clk);
        chk_drv("R3 before tOIT", -1);
        @(negedge clk);
        chk_drv("R3 drive-high", 1);

        // R2 reserved codes ignored
        for (int rc = 3; rc < 8; rc++) begin
            if (rc == 4) continue;
            send_cmd(rc[2:0]);
            repeat (TOIT + 1) @(negedge clk);
            chk_drv("R2 reserved code", 1);
        end

        // R4 drive-low
        send_cmd(3'b010);
        repeat (TOIT - 1) @(negedge clk);
        chk_drv("R4 before tOIT", 1);
        @(negedge clk);
        chk_drv("R4 drive-low", 0);

        // R6 restart: drive-high then exit one clock later
        send_cmd(3'b001);
        send_cmd(3'b000);
        repeat (TOIT - 1) @(negedge clk);
        chk_drv("R6 old target dropped", 0);
        @(negedge clk);
        chk_drv("R6 exit after restart", -1);

        // R5 exit from drive, then adjust turns drivers off
        send_cmd(3'b001);
        repeat (TOIT) @(negedge clk);
        chk_drv("R5 setup high", 1);
        send_cmd(3'b100);
        repeat (TOIT - 1) @(negedge clk);
        chk_drv("R5 before off", 1);
        @(negedge clk);
        chk_drv("R5 adjust off", -1);

        // R7/R8 sweep every code value
        for (int c = 0; c < 16; c++) begin
            burst(c[3:0], 0);
            exp_pu = step_val(exp_pu, c[3:2]);
            exp_pd = step_val(exp_pd, c[1:0]);
            chk("R7/R8 pu code sweep", pu_strength, exp_pu);
            chk("R7/R8 pd code sweep", pd_strength, exp_pd);
        end

        // R10 second strobe during open window ignored
        burst(4'b0000, 1);
        for (int k = 0; k < 10; k++) begin dq0_in = k[0]; @(negedge clk); end
        chk("R10 pu second strobe", pu_strength, exp_pu);
        chk("R10 pd second strobe", pd_strength, exp_pd);

        // R9 saturation up then down, mixed direction
        for (int i = 0; i < 18; i++) begin
            burst(4'b0101, 0);
            exp_pu = step_val(exp_pu, 2'b01);
            exp_pd = step_val(exp_pd, 2'b01);
        end
        chk("R9 pu ceiling", pu_strength, SMAX);
        chk("R9 pd ceiling", pd_strength, SMAX);
        for (int i = 0; i < 18; i++) begin
            burst(4'b1010, 0);
            exp_pu = step_val(exp_pu, 2'b10);
            exp_pd = step_val(exp_pd, 2'b10);
        end
        chk("R9 pu floor", pu_strength, 0);
        chk("R9 pd floor", pd_strength, 0);
        for (int i = 0; i < 3; i++) burst(4'b0110, 0);
        chk("R8 pu mixed", pu_strength, 3);
        chk("R8 pd mixed", pd_strength, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule